// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two byte-wide buses, called side A and side B. Each bus is modelled as a split triple: an input, an output and an output enable. Two controls pick the driven side, if any. One is an active-low output enable and the other is a direction input. Only one side is ever driven.

The driven side carries one of two values, chosen by a select input for that direction. The first is the other bus passed straight through in the same cycle. The second is a copy of that bus held in a per-direction storage register.

The storage registers share the system clock. Each one loads from its own bus when its capture strobe is high at a rising edge. The strobes do not depend on the output enable or the direction. A bus can therefore be sampled while the block is isolated, or while the other side is being driven.

An active-low asynchronous reset clears both registers to zero, so the stored values start out known.

Top module: `bus_xcvr_reg`

## Requirements
- R1: When `cap_a_i` is high at a rising edge of `clk_i`, the A-store register takes the value of `a_i`. When `cap_a_i` is low, the register keeps its value.
- R2: When `cap_b_i` is high at a rising edge of `clk_i`, the B-store register takes the value of `b_i`. When `cap_b_i` is low, the register keeps its value.
- R3: While `oe_ni` is 1, both `a_oe_o` and `b_oe_o` are 0.
- R4: While `oe_ni` is 0, `dir_i`=0 drives side A (`a_oe_o`=1, `b_oe_o`=0). `dir_i`=1 drives side B (`b_oe_o`=1, `a_oe_o`=0).
- R5: While side B is driven and `sel_ab_i`=0, `b_o` equals `a_i` in the same cycle.
- R6: While side B is driven and `sel_ab_i`=1, `b_o` equals the A-store register.
- R7: While side A is driven, `a_o` follows `sel_ba_i`. With `sel_ba_i`=0 it equals `b_i` in the same cycle. With `sel_ba_i`=1 it equals the B-store register.
- R8: The capture strobes act the same whatever the values of `oe_ni` and `dir_i`, including while both sides are isolated.
- R9: A register may be captured on the same edge in which it is the selected source. In that case the output shows the old stored value before the edge and the new value from the edge onward.
- R10: `a_oe_o` and `b_oe_o` are never both 1.
- R11: After `rst_ni` is asserted, both registers hold zero.
- R12: A data output whose enable is 0 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for both storage registers |
| rst_ni | input | 1 | Asynchronous reset, active low, clears both registers |
| oe_ni | input | 1 | Output enable, active low |
| dir_i | input | 1 | Selects the driven side: 0 drives A, 1 drives B |
| sel_ab_i | input | 1 | Source for side B: 0 is live A, 1 is stored A |
| sel_ba_i | input | 1 | Source for side A: 0 is live B, 1 is stored B |
| cap_a_i | input | 1 | Load the A-store register from a_i at the next edge |
| cap_b_i | input | 1 | Load the B-store register from b_i at the next edge |
| a_i | input | W | Bus A input value |
| a_o | output | W | Bus A output value |
| a_oe_o | output | 1 | Bus A output enable |
| b_i | input | W | Bus B input value |
| b_o | output | W | Bus B output value |
| b_oe_o | output | 1 | Bus B output enable |

## Verification
Two functions can fall in the same cycle. One is capturing a register. The other is driving that same register onto the opposite bus. The bench provokes this by raising the capture strobe of the selected source while its stored value is on the output, and by capturing both registers at once during transfers in both directions. The scoreboard judges each case against a model in which registers update only at the edge. It therefore expects the old value in the capture cycle and the new value in the next cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 8;

  typedef enum logic {
    DRV_A_SIDE = 1'b0,
    DRV_B_SIDE = 1'b1
  } drive_side_e;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux #(
  parameter int unsigned W = 8
) (
  input  logic         en_i,
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] q_o
);
  import xcvr_pkg::*;

  always_comb begin
    if (!en_i)                  q_o = '0;  // undriven side reads zero
    else if (sel_i == SRC_LIVE) q_o = live_i;
    else                        q_o = stored_i;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl (
  input  logic oe_ni,
  input  logic dir_i,
  output logic a_en_o,
  output logic b_en_o
);
  import xcvr_pkg::*;

  always_comb begin
    a_en_o = 1'b0;
    b_en_o = 1'b0;
    if (!oe_ni) begin
      if (dir_i == DRV_B_SIDE) b_en_o = 1'b1;
      else                     a_en_o = 1'b1;
    end
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int unsigned W = xcvr_pkg::XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         oe_ni,
  input  logic         dir_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  localparam int unsigned NDIR = 2;  // 0: A->B, 1: B->A

  logic [NDIR-1:0][W-1:0] src_bus, stored, dst_val;
  logic [NDIR-1:0]        cap, sel, dst_en;
  logic                   a_en, b_en;

  xcvr_drive_ctl u_ctl (
    .oe_ni (oe_ni),
    .dir_i (dir_i),
    .a_en_o(a_en),
    .b_en_o(b_en)
  );

  assign src_bus[0] = a_i;
  assign src_bus[1] = b_i;
  assign cap[0]     = cap_a_i;
  assign cap[1]     = cap_b_i;
  assign sel[0]     = sel_ab_i;
  assign sel[1]     = sel_ba_i;
  assign dst_en[0]  = b_en;
  assign dst_en[1]  = a_en;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_store_reg #(.W(W)) u_store (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cap_i (cap[d]),
      .d_i   (src_bus[d]),
      .q_o   (stored[d])
    );

    xcvr_src_mux #(.W(W)) u_mux (
      .en_i    (dst_en[d]),
      .sel_i   (sel[d]),
      .live_i  (src_bus[d]),
      .stored_i(stored[d]),
      .q_o     (dst_val[d])
    );
  end

  assign b_o    = dst_val[0];
  assign a_o    = dst_val[1];
  assign b_oe_o = b_en;
  assign a_oe_o = a_en;
endmodule

// File: rtl/xcvr_reg_chk.sv
module xcvr_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         oe_ni,
  input logic         sel_ab_i,
  input logic         sel_ba_i,
  input logic         cap_a_i,
  input logic         cap_b_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_o,
  input logic         b_oe_o
);
  AST_ONE_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({a_oe_o, b_oe_o}) <= 1);  // R10
  AST_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!a_oe_o && !b_oe_o));  // R3
  AST_LIVE_TO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !sel_ab_i) |-> (b_o == a_i));  // R5
  AST_LIVE_TO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && !sel_ba_i) |-> (a_o == b_i));  // R7
  AST_QUIET_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_oe_o |-> (a_o == '0));  // R12
  AST_QUIET_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_oe_o |-> (b_o == '0));  // R12
  AST_CAPTURE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_a_i |=> (!(b_oe_o && sel_ab_i) || b_o == $past(a_i)));  // R1
  AST_CAPTURE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_b_i |=> (!(a_oe_o && sel_ba_i) || a_o == $past(b_i)));  // R2
  AST_HOLD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_a_i && b_oe_o && sel_ab_i) |=> (!(b_oe_o && sel_ab_i) || $stable(b_o)));  // R1
  AST_HOLD_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_b_i && a_oe_o && sel_ba_i) |=> (!(a_oe_o && sel_ba_i) || $stable(a_o)));  // R2
endmodule

bind bus_xcvr_reg xcvr_reg_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .oe_ni   (oe_ni),
  .sel_ab_i(sel_ab_i),
  .sel_ba_i(sel_ba_i),
  .cap_a_i (cap_a_i),
  .cap_b_i (cap_b_i),
  .a_i     (a_i),
  .a_o     (a_o),
  .a_oe_o  (a_oe_o),
  .b_i     (b_i),
  .b_o     (b_o),
  .b_oe_o  (b_oe_o)
);

// File: tb/bus_xcvr_reg_tb_top.sv
`timescale 1ns/1ps
module bus_xcvr_reg_tb_top;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         oe_n = 1'b1, dir = 1'b0, sab = 1'b0, sba = 1'b0, ca = 1'b0, cb = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  always #2 clk = ~clk;

  bus_xcvr_reg #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .oe_ni(oe_n), .dir_i(dir),
    .sel_ab_i(sab), .sel_ba_i(sba), .cap_a_i(ca), .cap_b_i(cb),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  typedef struct {
    logic         a_oe;
    logic         b_oe;
    logic [W-1:0] a;
    logic [W-1:0] b;
    string        tag;
  } item_t;

  item_t        exp_q[$];
  logic [W-1:0] ma = '0, mb = '0;  // R11: model starts cleared
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  task automatic step(input logic o, input logic d, input logic s_ab, input logic s_ba,
                      input logic c_a, input logic c_b, input logic [W-1:0] av,
                      input logic [W-1:0] bv, input string tag);
    item_t it;
    @(negedge clk);
    oe_n = o; dir = d; sab = s_ab; sba = s_ba; ca = c_a; cb = c_b; a_in = av; b_in = bv;
    it.a_oe = !o && !d;
    it.b_oe = !o && d;
    it.b    = it.b_oe ? (s_ab ? ma : av) : '0;
    it.a    = it.a_oe ? (s_ba ? mb : bv) : '0;
    it.tag  = tag;
    exp_q.push_back(it);
    @(posedge clk);
    if (c_a) ma = av;
    if (c_b) mb = bv;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() != 0) begin
        item_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (a_oe !== e.a_oe || b_oe !== e.b_oe || a_out !== e.a || b_out !== e.b) begin
          n_fail++;
          $display("FAIL %s: actual a_oe=%b b_oe=%b a=%h b=%h expected a_oe=%b b_oe=%b a=%h b=%h",
                   e.tag, a_oe, b_oe, a_out, b_out, e.a_oe, e.b_oe, e.a, e.b);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    n_chk++;  // reset state: isolated
    if (a_oe !== 1'b0 || b_oe !== 1'b0 || a_out !== '0 || b_out !== '0) begin
      n_fail++;
      $display("FAIL R3 reset: actual a_oe=%b b_oe=%b a=%h b=%h expected 0 0 00 00",
               a_oe, b_oe, a_out, b_out);
    end
    rst_n = 1'b1;

    // R11: stored values read zero after reset
    step(0, 1, 1, 0, 0, 0, 8'hA5, 8'h3C, "R11 stored A");
    step(0, 0, 0, 1, 0, 0, 8'hA5, 8'h3C, "R11 stored B");

    // R3, R12, R8: capture while isolated
    step(1, 0, 1, 1, 1, 1, 8'h5A, 8'hC3, "R8 isolated capture");
    step(1, 1, 0, 0, 0, 0, 8'hFF, 8'hFF, "R3 R12 isolation");
    step(0, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R6 R1 stored A");
    step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R7 R2 stored B");

    // R1/R2 hold without strobe
    step(0, 1, 1, 0, 0, 0, 8'h77, 8'h88, "R1 hold");
    step(0, 0, 0, 1, 0, 0, 8'h77, 8'h88, "R2 hold");

    // R5, R7 live patterns
    for (int i = 0; i < 8; i++) begin
      step(0, 1, 0, 0, 0, 0, 8'(1 << i), 8'(~(1 << i)), "R5 live A to B");
      step(0, 0, 0, 0, 0, 0, 8'(i * 37), 8'(~(1 << i)), "R7 live B to A");
    end

    // R9: capture of the selected source on the same edge
    step(0, 1, 1, 0, 1, 0, 8'h11, 8'h00, "R9 capture cycle A");
    step(0, 1, 1, 0, 0, 0, 8'h22, 8'h00, "R9 after edge A");
    step(0, 0, 0, 1, 0, 1, 8'h00, 8'h99, "R9 capture cycle B");
    step(0, 0, 0, 1, 0, 0, 8'h00, 8'h44, "R9 after edge B");

    // R8/R2: capture B while B is being driven; R1 capture A while A is driven
    step(0, 1, 1, 0, 0, 1, 8'h01, 8'hE7, "R8 capture B while B driven");
    step(0, 0, 0, 1, 1, 0, 8'h6D, 8'h02, "R2 stored B after capture");
    step(0, 1, 1, 0, 0, 0, 8'h03, 8'h04, "R1 A captured while A driven");

    // R4 R10: every control combination with changing data and captures
    for (int k = 0; k < 64; k++) begin
      step(k[0], k[1], k[2], k[3], k[4], k[5], 8'(k * 29 + 5), 8'(k * 83 + 17),
           "R4 R10 combination");
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule